// File: doc/BRIEF.md
# Paged Nonvolatile Write Commit Engine

This block holds a small byte-addressed store that stands in for nonvolatile cells behind an internal byte bus. Sixteen general bytes sit at 00h–0Fh and three setting registers at F8h, F9h and FAh. A host, usually a serial-bus front end, loads a byte address and then pushes data bytes. The bytes collect in a two-entry page buffer, and a pointer steps through that buffer without ever leaving the page. When the host signals the end of the transaction, the engine writes the page into the backing array. During that commit a write-time counter runs and `busy` is held high.

The live setting registers drive three 8-bit setting outputs. A setting above 3Fh is out of range, and its output is flagged as high-impedance. The live registers are recalled from the backing array on the first clock after reset. After that they follow the array each time a commit completes. The write time is a parameter counted in clock cycles.

Top module: `nvpage_commit`

## Requirements
- R1: Reads are combinational on `rd_addr` and return the committed array contents. Addresses 00h–0Fh are general bytes and F8h/F9h/FAh are setting registers 0/1/2. Every other address reads as 00h.
- R2: Reset sets the general bytes to 00h and the setting registers to 3Fh. `busy` is 1 while `rst_n` is low.
- R3: The live setting outputs read 00h while reset is held. On the first clock edge after reset release, they load from the stored settings and `busy` drops to 0.
- R4: `addr_load` sets the write pointer. Each data byte goes to the current pointer, and the pointer's bit 0 then toggles, so it wraps inside the two-byte page (base = even address). A third byte in one transaction overwrites the first.
- R5: A commit starts only when `stop` is sampled with at least one data byte buffered for a page that holds a mapped address. `busy` then stays high for exactly WR_CYCLES cycles, starting with the cycle after `stop`. A `stop` with no data byte starts no commit.
- R6: A commit changes only the bytes written in that transaction. The other byte of the page keeps its value.
- R7: The array and the setting outputs change only on the clock edge at which `busy` falls at the end of a commit.
- R8: `set_hiz[k]` is 1 exactly when setting k holds a value above 3Fh. Setting k is `set_val[8k+7:8k]`.
- R9: While `busy` is 1, `addr_load`, `wr_en` and `stop` are ignored.
- R10: Bytes aimed at unmapped addresses are buffered but never stored. A page with no mapped address starts no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Load the write pointer from `addr_in`; starts a new page |
| addr_in | input | 8 | Byte address for `addr_load` |
| wr_en | input | 1 | Write `wr_data` at the pointer |
| wr_data | input | 8 | Data byte |
| stop | input | 1 | End of transaction; may start a commit |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Committed byte at `rd_addr` |
| busy | output | 1 | Recall or commit in progress |
| set_val | output | 24 | Live settings, setting 0 in bits 7:0 |
| set_hiz | output | 3 | High-impedance flag per setting |

## Verification
The assertions assume that `addr_load`, `wr_en` and `stop` are never raised in the same cycle. They also assume these inputs are level-sampled on the rising edge and change only between edges. The bench drives each operation as a single-cycle pulse shortly after the falling edge, with an idle cycle in between. It also deliberately issues full operations while a commit is still running.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_COMMIT = 2'd2
  } seq_st_t;
endpackage

// File: rtl/nvp_page_buf.sv
module nvp_page_buf #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 addr_load,
  input  logic [AW-1:0]        addr_in,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  input  logic                 clr,
  output logic [AW-2:0]        page,
  output logic [1:0][DW-1:0]   pg_data,
  output logic [1:0]           mask
);
  logic [AW-1:0]      ptr_q, ptr_d;
  logic [1:0][DW-1:0] data_q, data_d;
  logic [1:0]         mask_q, mask_d;

  always_comb begin
    ptr_d  = ptr_q;
    data_d = data_q;
    mask_d = mask_q;
    if (accept && addr_load) begin
      ptr_d  = addr_in;
      mask_d = '0;
    end else if (accept && wr_en) begin
      data_d[ptr_q[0]] = wr_data;
      mask_d[ptr_q[0]] = 1'b1;
      ptr_d            = {ptr_q[AW-1:1], ~ptr_q[0]};
    end
    if (clr) mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      data_q <= data_d;
      mask_q <= mask_d;
    end
  end

  assign page    = ptr_q[AW-1:1];
  assign pg_data = data_q;
  assign mask    = mask_q;

  // R9
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(data_q) && $stable(ptr_q)));
endmodule

// File: rtl/nvp_seq.sv
module nvp_seq
  import nvp_pkg::*;
#(
  parameter int AW         = 8,
  parameter int WR_CYCLES  = 40,
  parameter int USER_BYTES = 16,
  parameter int SET_BASE   = 248,
  parameter int NUM_SET    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop,
  input  logic [1:0]    mask,
  input  logic [AW-2:0] page,
  output logic          busy,
  output logic          done,
  output logic          recall,
  output logic          clr
);
  localparam int CW        = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam int USER_PG   = USER_BYTES / 2;
  localparam int SET_PG_LO = SET_BASE / 2;
  localparam int SET_PG_HI = (SET_BASE + NUM_SET - 1) / 2;

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          page_ok;

  always_comb begin
    page_ok = (int'(page) < USER_PG) ||
              ((int'(page) >= SET_PG_LO) && (int'(page) <= SET_PG_HI));
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    recall = 1'b0;
    clr    = 1'b0;
    case (st_q)
      ST_RECALL: begin
        recall = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_IDLE: begin
        if (stop) begin
          if ((|mask) && page_ok) begin
            st_d  = ST_COMMIT;
            cnt_d = CW'(WR_CYCLES - 1);
          end else begin
            clr = 1'b1;
          end
        end
      end
      ST_COMMIT: begin
        if (cnt_q == '0) begin
          done = 1'b1;
          clr  = 1'b1;
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RECALL;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != ST_IDLE);

  // R5
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));
endmodule

// File: rtl/nvp_store.sv
module nvp_store #(
  parameter int             AW         = 8,
  parameter int             DW         = 8,
  parameter int             USER_BYTES = 16,
  parameter int             SET_BASE   = 248,
  parameter int             NUM_SET    = 3,
  parameter logic [DW-1:0]  USER_DFLT  = '0,
  parameter logic [DW-1:0]  SET_DFLT   = 8'h3F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [AW-2:0]              page,
  input  logic [1:0][DW-1:0]         pg_data,
  input  logic [1:0]                 mask,
  input  logic [AW-1:0]              rd_addr,
  output logic [DW-1:0]              rd_data,
  output logic [NUM_SET-1:0][DW-1:0] set_nxt
);
  logic [USER_BYTES-1:0][DW-1:0] user_q, user_d;
  logic [NUM_SET-1:0][DW-1:0]    set_q, set_d;

  for (genvar i = 0; i < USER_BYTES; i++) begin : g_user
    localparam logic [AW-2:0] PG = (AW-1)'(i / 2);
    assign user_d[i] = (commit && (page == PG) && mask[i % 2]) ?
                       pg_data[i % 2] : user_q[i];
  end

  for (genvar j = 0; j < NUM_SET; j++) begin : g_set
    localparam int            AD = SET_BASE + j;
    localparam logic [AW-2:0] PG = (AW-1)'(AD / 2);
    assign set_d[j] = (commit && (page == PG) && mask[AD % 2]) ?
                      pg_data[AD % 2] : set_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_BYTES; i++) user_q[i] <= USER_DFLT;
      for (int j = 0; j < NUM_SET; j++)    set_q[j]  <= SET_DFLT;
    end else if (commit) begin
      user_q <= user_d;
      set_q  <= set_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < USER_BYTES; i++)
      if (rd_addr == AW'(i)) rd_data = user_q[i];
    for (int j = 0; j < NUM_SET; j++)
      if (rd_addr == AW'(SET_BASE + j)) rd_data = set_q[j];
  end

  assign set_nxt = set_d;

  // R7
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(user_q) && $stable(set_q)));
endmodule

// File: rtl/nvp_live.sv
module nvp_live #(
  parameter int DW      = 8,
  parameter int NUM_SET = 3,
  parameter int MAX_POS = 63
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [NUM_SET-1:0][DW-1:0] src,
  output logic [NUM_SET-1:0][DW-1:0] live,
  output logic [NUM_SET-1:0]         hiz
);
  logic [NUM_SET-1:0][DW-1:0] live_q, live_d;

  always_comb begin
    live_d = live_q;
    if (load) live_d = src;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else if (load) live_q <= live_d;
  end

  for (genvar k = 0; k < NUM_SET; k++) begin : g_hiz
    assign hiz[k] = (live_q[k] > DW'(MAX_POS));
  end

  assign live = live_q;
endmodule

// File: rtl/nvpage_commit.sv
module nvpage_commit #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int USER_BYTES = 16,
  parameter int SET_BASE   = 248,
  parameter int NUM_SET    = 3,
  parameter int MAX_POS    = 63,
  parameter int WR_CYCLES  = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_load,
  input  logic [AW-1:0]         addr_in,
  input  logic                  wr_en,
  input  logic [DW-1:0]         wr_data,
  input  logic                  stop,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data,
  output logic                  busy,
  output logic [NUM_SET*DW-1:0] set_val,
  output logic [NUM_SET-1:0]    set_hiz
);
  logic [AW-2:0]              page;
  logic [1:0][DW-1:0]         pg_data;
  logic [1:0]                 mask;
  logic                       done, recall, clr, busy_i;
  logic [NUM_SET-1:0][DW-1:0] set_nxt, live;

  nvp_page_buf #(.AW(AW), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .accept(!busy_i),
    .addr_load(addr_load), .addr_in(addr_in),
    .wr_en(wr_en), .wr_data(wr_data), .clr(clr),
    .page(page), .pg_data(pg_data), .mask(mask)
  );

  nvp_seq #(.AW(AW), .WR_CYCLES(WR_CYCLES), .USER_BYTES(USER_BYTES),
            .SET_BASE(SET_BASE), .NUM_SET(NUM_SET)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop(stop), .mask(mask), .page(page),
    .busy(busy_i), .done(done), .recall(recall), .clr(clr)
  );

  nvp_store #(.AW(AW), .DW(DW), .USER_BYTES(USER_BYTES),
              .SET_BASE(SET_BASE), .NUM_SET(NUM_SET)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(done), .page(page),
    .pg_data(pg_data), .mask(mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .set_nxt(set_nxt)
  );

  nvp_live #(.DW(DW), .NUM_SET(NUM_SET), .MAX_POS(MAX_POS)) u_live (
    .clk(clk), .rst_n(rst_n), .load(recall | done), .src(set_nxt),
    .live(live), .hiz(set_hiz)
  );

  assign set_val = live;
  assign busy    = busy_i;

  // R7
  set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(set_val) |-> $past(busy));
endmodule

// File: tb/sim_nvpage_commit.sv
`timescale 1ns/1ps
module sim_nvpage_commit;
  localparam int WR = 40;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_load = 0, wr_en = 0, stop = 0;
  logic [7:0]  addr_in = 0, wr_data = 0, rd_addr = 0;
  logic [7:0]  rd_data;
  logic        busy;
  logic [23:0] set_val;
  logic [2:0]  set_hiz;

  int checks = 0, errors = 0;
  bit cmp_on = 0;

  nvpage_commit #(.WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wr_en(wr_en), .wr_data(wr_data), .stop(stop), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .set_val(set_val), .set_hiz(set_hiz)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_st, m_cnt, m_ptr;
  int m_mem [256];
  int m_live [3];
  int m_buf [2];
  bit m_mask [2];

  function automatic bit mapped(int a);
    return (a < 16) || (a >= 248 && a <= 250);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ptr = 0;
      for (int a = 0; a < 256; a++) m_mem[a] = (a >= 248 && a <= 250) ? 63 : 0;
      for (int k = 0; k < 3; k++) m_live[k] = 0;
      for (int b = 0; b < 2; b++) begin m_buf[b] = 0; m_mask[b] = 0; end
    end else if (m_st == 0) begin
      for (int k = 0; k < 3; k++) m_live[k] = m_mem[248 + k];
      m_st = 1;
    end else if (m_st == 2) begin
      if (m_cnt == 0) begin
        for (int b = 0; b < 2; b++)
          if (m_mask[b] && mapped((m_ptr / 2) * 2 + b)) m_mem[(m_ptr / 2) * 2 + b] = m_buf[b];
        for (int k = 0; k < 3; k++) m_live[k] = m_mem[248 + k];
        m_mask[0] = 0; m_mask[1] = 0;
        m_st = 1;
      end else m_cnt--;
    end else begin
      if (stop) begin
        if ((m_mask[0] || m_mask[1]) &&
            (mapped((m_ptr / 2) * 2) || mapped((m_ptr / 2) * 2 + 1))) begin
          m_st = 2; m_cnt = WR - 1;
        end else begin
          m_mask[0] = 0; m_mask[1] = 0;
        end
      end
      if (addr_load) begin
        m_ptr = addr_in; m_mask[0] = 0; m_mask[1] = 0;
      end else if (wr_en) begin
        m_buf[m_ptr % 2] = wr_data;
        m_mask[m_ptr % 2] = 1;
        m_ptr = (m_ptr / 2) * 2 + (1 - (m_ptr % 2));
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h @%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (cmp_on) begin
    int exp_rd;
    exp_rd = mapped(rd_addr) ? m_mem[rd_addr] : 0;
    chk(busy == (m_st != 1), "R5 busy", busy, m_st != 1);
    chk(rd_data == 8'(exp_rd), "R1 rd_data", rd_data, exp_rd);
    for (int k = 0; k < 3; k++) begin
      chk(set_val[8*k +: 8] == 8'(m_live[k]), "R7 set_val", set_val[8*k +: 8], m_live[k]);
      chk(set_hiz[k] == (m_live[k] > 63), "R8 set_hiz", set_hiz[k], m_live[k] > 63);
    end
  end

  task automatic op(bit al, logic [7:0] a, bit we, logic [7:0] d, bit st);
    @(negedge clk); #2;
    addr_load = al; addr_in = a; wr_en = we; wr_data = d; stop = st;
    @(negedge clk); #2;
    addr_load = 0; wr_en = 0; stop = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
    rd_addr = a; #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); #2; end
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    #1 cmp_on = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b1, "R2 busy in reset", busy, 1);
    chk(set_val == 24'h0, "R3 live before recall", set_val, 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    chk(set_val == 24'h3F3F3F, "R3 recall", set_val, 24'h3F3F3F);
    chk(busy == 1'b0, "R3 busy after recall", busy, 0);
    rd_chk(8'h00, 8'h00, "R2 user default");
    rd_chk(8'hF9, 8'h3F, "R1 setting map");
    rd_chk(8'hFB, 8'h00, "R1 reserved read");

    // single byte, odd address
    op(1, 8'h03, 0, 0, 0);
    op(0, 0, 1, 8'hAB, 0);
    op(0, 0, 0, 0, 1);
    wait_idle(n);
    chk(n == WR, "R5 busy length", n, WR);
    rd_chk(8'h03, 8'hAB, "R6 written byte");
    rd_chk(8'h02, 8'h00, "R6 untouched byte");

    // three bytes wrap within page
    op(1, 8'h04, 0, 0, 0);
    op(0, 0, 1, 8'h11, 0);
    op(0, 0, 1, 8'h22, 0);
    op(0, 0, 1, 8'h33, 0);
    op(0, 0, 0, 0, 1);
    wait_idle(n);
    rd_chk(8'h04, 8'h33, "R4 wrap overwrite");
    rd_chk(8'h05, 8'h22, "R4 second byte");
    rd_chk(8'h06, 8'h00, "R4 next page untouched");

    // settings page
    op(1, 8'hF8, 0, 0, 0);
    op(0, 0, 1, 8'h10, 0);
    op(0, 0, 1, 8'h50, 0);
    op(0, 0, 0, 0, 1);
    repeat (5) @(negedge clk);
    #2;
    chk(set_val == 24'h3F3F3F, "R7 hold during commit", set_val, 24'h3F3F3F);
    wait_idle(n);
    chk(set_val == 24'h3F5010, "R7 settings after commit", set_val, 24'h3F5010);
    chk(set_hiz == 3'b010, "R8 hiz flag", set_hiz, 3'b010);

    // writes while busy
    op(1, 8'h0A, 0, 0, 0);
    op(0, 0, 1, 8'h5A, 0);
    op(0, 0, 0, 0, 1);
    op(1, 8'h00, 0, 0, 0);
    op(0, 0, 1, 8'h77, 0);
    op(0, 0, 0, 0, 1);
    wait_idle(n);
    rd_chk(8'h00, 8'h00, "R9 ignored while busy");
    rd_chk(8'h0A, 8'h5A, "R9 running commit kept");
    @(negedge clk); #2;
    chk(busy == 1'b0, "R9 no second commit", busy, 0);

    // unmapped page and empty transaction
    op(1, 8'hFC, 0, 0, 0);
    op(0, 0, 1, 8'h99, 0);
    op(0, 0, 0, 0, 1);
    chk(busy == 1'b0, "R10 no commit for unmapped page", busy, 0);
    rd_chk(8'hFC, 8'h00, "R10 unmapped not stored");
    op(1, 8'h06, 0, 0, 0);
    op(0, 0, 0, 0, 1);
    chk(busy == 1'b0, "R5 stop without data", busy, 0);

    // mixed page: mapped FAh, unmapped FBh
    op(1, 8'hFA, 0, 0, 0);
    op(0, 0, 1, 8'h41, 0);
    op(0, 0, 1, 8'h12, 0);
    op(0, 0, 0, 0, 1);
    wait_idle(n);
    chk(set_val[23:16] == 8'h41, "R8 setting 2 value", set_val[23:16], 8'h41);
    chk(set_hiz == 3'b110, "R8 hiz flags", set_hiz, 3'b110);
    rd_chk(8'hFB, 8'h00, "R10 reserved byte dropped");

    // reset restores defaults
    @(negedge clk); #2;
    rst_n = 1'b0;
    @(negedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(set_val == 24'h3F3F3F, "R2 defaults after reset", set_val, 24'h3F3F3F);
    rd_chk(8'h03, 8'h00, "R2 user cleared");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule